// File: doc/BRIEF.md
# Dual Scaled Timeout Timer Unit

This block holds two independent timeout watchdogs for a serial display link controller, both set up from one 32-bit control word. The transmit watchdog counts cycles of the high-speed byte clock. The receive watchdog counts cycles of the controller's functional clock. Each watchdog is used to catch a bus turn-around that never completes. Each one has four controls: an enable bit, two multiplier select bits and a 13-bit base count.

A start strobe loads the down-counter with the base count scaled by the selected multipliers. A stop strobe, which marks that the guarded event completed, halts the count quietly. If the count runs out, the watchdog sets a sticky interrupt, which stays set until a clear pulse arrives. The control word is written through a plain write port and can always be read back. A rewritten control word is used from the next start strobe onward, so a new value never disturbs a count that is already running.

Top module: `link_turnaround_timers`

## Requirements
- R1: After reset the control word reads 0x7FFF7FFF. Both enables are 0, all four multiplier bits are 1, both base counts are 0x1FFF, and both interrupts are low.
- R2: A write on the register port replaces the whole control word, and the read port returns the stored word on the next cycle.
- R3: Transmit field layout: bit 31 is the enable, bit 30 selects ×16, bit 29 selects ×8 and bits 28:16 hold the base. The loaded count L is base × (bit30 ? 16 : 1) × (bit29 ? 8 : 1). The transmit interrupt is low for L byte-clock edges after the start edge and high at edge L+1. A base of 0 therefore expires on the first edge after start.
- R4: Receive field layout: bit 15 is the enable, bit 14 selects ×16, bit 13 selects ×4 and bits 12:0 hold the base. L is base × (bit14 ? 16 : 1) × (bit13 ? 4 : 1). The receive interrupt follows the same timing as R3, counted in functional-clock edges.
- R5: An interrupt stays high until its clear input is pulsed, and it is low on the edge after the clear. If an expiry and a clear fall on the same edge, the interrupt ends up high.
- R6: A stop strobe halts a running count without raising the interrupt. A stop wins over a start or an expiry on the same edge.
- R7: While a timer's enable bit is 0, its start strobes are ignored. Clearing the enable bit during a count halts that count and no interrupt follows.
- R8: A control word written while a count runs does not change that count's expiry. The new value applies from the next start strobe.
- R9: A start strobe on a running timer restarts it from a fresh load, and the expiry timing of R3 and R4 is counted from the new start edge.
- R10: Activity on one timer never raises the other timer's interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_func | input | 1 | Functional clock: register port and receive timer |
| rst_func_n | input | 1 | Asynchronous active-low reset, functional domain |
| clk_byte | input | 1 | High-speed byte clock: transmit timer |
| rst_byte_n | input | 1 | Asynchronous active-low reset, byte domain |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Stored control word |
| tx_start | input | 1 | Transmit timer start strobe |
| tx_stop | input | 1 | Transmit timer stop (event done) strobe |
| tx_irq_clr | input | 1 | Transmit interrupt clear pulse |
| tx_irq | output | 1 | Sticky transmit timeout interrupt |
| rx_start | input | 1 | Receive timer start strobe |
| rx_stop | input | 1 | Receive timer stop (event done) strobe |
| rx_irq_clr | input | 1 | Receive interrupt clear pulse |
| rx_irq | output | 1 | Sticky receive timeout interrupt |

## Verification
The bench checks the expiry edge to the exact cycle for random bases and every multiplier combination. A scaling bug or an off-by-one counter would raise the interrupt one edge early or late. A base of zero is tested because a wrapping counter would run about a million cycles instead of expiring on the first edge. The bench also drives a clear on the expiry edge, a stop on the start edge, an enable dropped during a count, and a rewrite during a count. A design that got these wrong would lose the timeout, report a timeout for an event that completed, or change the length of a count that was already running.

// File: rtl/lnk_tmo_pkg.sv
package lnk_tmo_pkg;

  localparam int unsigned TMO_BASE_W = 13;

  typedef struct packed {
    logic                  en;
    logic                  mul_hi;
    logic                  mul_lo;
    logic [TMO_BASE_W-1:0] base;
  } tmo_field_t;

  function automatic tmo_field_t field_of(input logic [TMO_BASE_W+2:0] raw);
    tmo_field_t f;
    f.en     = raw[TMO_BASE_W+2];
    f.mul_hi = raw[TMO_BASE_W+1];
    f.mul_lo = raw[TMO_BASE_W];
    f.base   = raw[TMO_BASE_W-1:0];
    return f;
  endfunction

endpackage

// File: rtl/lnk_tmo_cfg.sv
module lnk_tmo_cfg #(
  parameter int unsigned BASE_W = 13,
  localparam int unsigned HALF_W = BASE_W + 3,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word
);
  localparam logic [HALF_W-1:0] HALF_RST = {1'b0, 1'b1, 1'b1, {BASE_W{1'b1}}};
  localparam logic [WORD_W-1:0] WORD_RST = {HALF_RST, HALF_RST};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word <= WORD_RST;
    else if (wr) word <= wdata;
  end
endmodule

// File: rtl/lnk_tmo_counter.sv
module lnk_tmo_counter #(
  parameter int unsigned BASE_W = 13,
  parameter int unsigned SH_HI  = 4,
  parameter int unsigned SH_LO  = 3,
  localparam int unsigned CNT_W = BASE_W + SH_HI + SH_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              mul_hi,
  input  logic              mul_lo,
  input  logic [BASE_W-1:0] base,
  input  logic              start,
  input  logic              stop,
  input  logic              irq_clr,
  output logic              irq,
  output logic              running,
  output logic              expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  function automatic logic [CNT_W-1:0] scaled_load(input logic [BASE_W-1:0] b,
                                                   input logic hi, input logic lo);
    logic [CNT_W-1:0] v;
    v = CNT_W'(b);
    if (hi) v = v << SH_HI;
    if (lo) v = v << SH_LO;
    return v;
  endfunction

  assign load_val = scaled_load(base, mul_hi, mul_lo);
  assign expire   = running && en && !stop && !start && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!en || stop) begin
      running <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= load_val;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= expire | (irq & ~irq_clr);
  end
endmodule

// File: rtl/link_turnaround_timers.sv
module link_turnaround_timers #(
  parameter int unsigned BASE_W    = lnk_tmo_pkg::TMO_BASE_W,
  parameter int unsigned TX_SH_HI  = 4,
  parameter int unsigned TX_SH_LO  = 3,
  parameter int unsigned RX_SH_HI  = 4,
  parameter int unsigned RX_SH_LO  = 2,
  localparam int unsigned HALF_W   = BASE_W + 3,
  localparam int unsigned WORD_W   = 2 * HALF_W
) (
  input  logic              clk_func,
  input  logic              rst_func_n,
  input  logic              clk_byte,
  input  logic              rst_byte_n,
  input  logic              cfg_wr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              tx_start,
  input  logic              tx_stop,
  input  logic              tx_irq_clr,
  output logic              tx_irq,
  input  logic              rx_start,
  input  logic              rx_stop,
  input  logic              rx_irq_clr,
  output logic              rx_irq
);
  import lnk_tmo_pkg::*;

  logic [WORD_W-1:0] word;
  tmo_field_t        tx_f, rx_f;
  logic              tx_running, tx_expire, rx_running, rx_expire;

  lnk_tmo_cfg #(.BASE_W(BASE_W)) u_cfg (
    .clk(clk_func), .rst_n(rst_func_n), .wr(cfg_wr), .wdata(cfg_wdata), .word(word)
  );

  assign cfg_rdata = word;
  assign tx_f      = field_of(word[WORD_W-1:HALF_W]);
  assign rx_f      = field_of(word[HALF_W-1:0]);

  lnk_tmo_counter #(.BASE_W(BASE_W), .SH_HI(TX_SH_HI), .SH_LO(TX_SH_LO)) u_tx (
    .clk(clk_byte), .rst_n(rst_byte_n),
    .en(tx_f.en), .mul_hi(tx_f.mul_hi), .mul_lo(tx_f.mul_lo), .base(tx_f.base),
    .start(tx_start), .stop(tx_stop), .irq_clr(tx_irq_clr),
    .irq(tx_irq), .running(tx_running), .expire(tx_expire)
  );

  lnk_tmo_counter #(.BASE_W(BASE_W), .SH_HI(RX_SH_HI), .SH_LO(RX_SH_LO)) u_rx (
    .clk(clk_func), .rst_n(rst_func_n),
    .en(rx_f.en), .mul_hi(rx_f.mul_hi), .mul_lo(rx_f.mul_lo), .base(rx_f.base),
    .start(rx_start), .stop(rx_stop), .irq_clr(rx_irq_clr),
    .irq(rx_irq), .running(rx_running), .expire(rx_expire)
  );
endmodule

// File: rtl/link_turnaround_timers_chk.sv
module link_turnaround_timers_chk (
  input logic clk_func,
  input logic rst_func_n,
  input logic clk_byte,
  input logic rst_byte_n,
  input logic tx_en,
  input logic tx_run,
  input logic tx_exp,
  input logic tx_stop,
  input logic tx_irq,
  input logic tx_irq_clr,
  input logic rx_en,
  input logic rx_run,
  input logic rx_exp,
  input logic rx_stop,
  input logic rx_irq,
  input logic rx_irq_clr
);
  AST_TX_IRQ_STICKY: assert property (@(posedge clk_byte) disable iff (!rst_byte_n)
    tx_irq && !tx_irq_clr |=> tx_irq); // R5
  AST_RX_IRQ_STICKY: assert property (@(posedge clk_func) disable iff (!rst_func_n)
    rx_irq && !rx_irq_clr |=> rx_irq); // R5
  AST_TX_CLR_WORKS: assert property (@(posedge clk_byte) disable iff (!rst_byte_n)
    tx_irq_clr && !tx_exp |=> !tx_irq); // R5
  AST_RX_CLR_WORKS: assert property (@(posedge clk_func) disable iff (!rst_func_n)
    rx_irq_clr && !rx_exp |=> !rx_irq); // R5
  AST_TX_EXPIRE_SETS: assert property (@(posedge clk_byte) disable iff (!rst_byte_n)
    tx_exp |=> tx_irq); // R3
  AST_RX_EXPIRE_SETS: assert property (@(posedge clk_func) disable iff (!rst_func_n)
    rx_exp |=> rx_irq); // R4
  AST_TX_IRQ_CAUSE: assert property (@(posedge clk_byte) disable iff (!rst_byte_n)
    $rose(tx_irq) |-> $past(tx_exp)); // R3
  AST_RX_IRQ_CAUSE: assert property (@(posedge clk_func) disable iff (!rst_func_n)
    $rose(rx_irq) |-> $past(rx_exp)); // R4
  AST_TX_SINGLE_EXPIRE: assert property (@(posedge clk_byte) disable iff (!rst_byte_n)
    tx_exp |=> !tx_exp); // R3
  AST_TX_STOP_HALTS: assert property (@(posedge clk_byte) disable iff (!rst_byte_n)
    tx_stop |=> !tx_run); // R6
  AST_RX_STOP_HALTS: assert property (@(posedge clk_func) disable iff (!rst_func_n)
    rx_stop |=> !rx_run); // R6
  AST_TX_DISABLED_IDLE: assert property (@(posedge clk_byte) disable iff (!rst_byte_n)
    !tx_en |=> !tx_run); // R7
  AST_RX_DISABLED_IDLE: assert property (@(posedge clk_func) disable iff (!rst_func_n)
    !rx_en |=> !rx_run); // R7
endmodule

bind link_turnaround_timers link_turnaround_timers_chk i_chk (
  .clk_func(clk_func), .rst_func_n(rst_func_n), .clk_byte(clk_byte), .rst_byte_n(rst_byte_n),
  .tx_en(tx_f.en), .tx_run(tx_running), .tx_exp(tx_expire), .tx_stop(tx_stop),
  .tx_irq(tx_irq), .tx_irq_clr(tx_irq_clr),
  .rx_en(rx_f.en), .rx_run(rx_running), .rx_exp(rx_expire), .rx_stop(rx_stop),
  .rx_irq(rx_irq), .rx_irq_clr(rx_irq_clr)
);

// File: tb/test_link_turnaround_timers.sv
module test_link_turnaround_timers;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        tx_start = 1'b0, tx_stop = 1'b0, tx_irq_clr = 1'b0, tx_irq;
  logic        rx_start = 1'b0, rx_stop = 1'b0, rx_irq_clr = 1'b0, rx_irq;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  link_turnaround_timers i_link_turnaround_timers (
    .clk_func(clk), .rst_func_n(rst_n), .clk_byte(clk), .rst_byte_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_start(tx_start), .tx_stop(tx_stop), .tx_irq_clr(tx_irq_clr), .tx_irq(tx_irq),
    .rx_start(rx_start), .rx_stop(rx_stop), .rx_irq_clr(rx_irq_clr), .rx_irq(rx_irq)
  );

  // Field packing: enable, x16, xSmall, 13-bit base in each half; transmit half on top.
  function automatic logic [15:0] half(bit en, bit h, bit l, int unsigned b);
    return {en, h, l, 13'(b)};
  endfunction

  function automatic int unsigned exp_len(bit tx, bit h, bit l, int unsigned b);
    int unsigned f = 1;
    if (h) f = f * 16;
    if (l) f = f * (tx ? 8 : 4);
    return b * f;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(logic [31:0] w);
    cfg_wr = 1'b1; cfg_wdata = w;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic start(bit tx);
    if (tx) tx_start = 1'b1; else rx_start = 1'b1;
    tick();
    tx_start = 1'b0; rx_start = 1'b0;
  endtask

  task automatic stop(bit tx);
    if (tx) tx_stop = 1'b1; else rx_stop = 1'b1;
    tick();
    tx_stop = 1'b0; rx_stop = 1'b0;
  endtask

  task automatic clear_both();
    tx_irq_clr = 1'b1; rx_irq_clr = 1'b1;
    tick();
    tx_irq_clr = 1'b0; rx_irq_clr = 1'b0;
  endtask

  function automatic logic irq_of(bit tx);
    return tx ? tx_irq : rx_irq;
  endfunction

  // Strobe start, then expect low for L edges and high at edge L+1.
  task automatic run_expect(bit tx, int unsigned len, string req);
    start(tx);
    tick(len);
    check(req, 32'(irq_of(tx)), 32'd0);
    tick();
    check(req, 32'(irq_of(tx)), 32'd1);
    check("R10", 32'(irq_of(!tx)), 32'd0);
    clear_both();
    check("R5", 32'(irq_of(tx)), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    check("R1", cfg_rdata, 32'h7FFF7FFF);
    check("R1", {30'd0, tx_irq, rx_irq}, 32'd0);
    rst_n = 1'b1;
    tick();
    check("R1", cfg_rdata, 32'h7FFF7FFF);

    write_cfg(32'hA5A55A5A);
    check("R2", cfg_rdata, 32'hA5A55A5A);

    // Directed scaling and zero base.
    write_cfg({half(1, 1, 0, 3), half(0, 0, 0, 0)});
    run_expect(1, exp_len(1, 1, 0, 3), "R3");
    write_cfg({half(1, 0, 0, 0), half(0, 0, 0, 0)});
    run_expect(1, 0, "R3");
    write_cfg({half(0, 0, 0, 0), half(1, 0, 1, 5)});
    run_expect(0, exp_len(0, 0, 1, 5), "R4");
    write_cfg({half(0, 0, 0, 0), half(1, 1, 1, 0)});
    run_expect(0, 0, "R4");

    // Sticky and clear racing the expiry edge.
    write_cfg({half(1, 0, 0, 12), half(0, 0, 0, 0)});
    start(1);
    tick(12);
    tx_irq_clr = 1'b1;
    tick();
    tx_irq_clr = 1'b0;
    check("R5", 32'(tx_irq), 32'd1);
    tick(20);
    check("R5", 32'(tx_irq), 32'd1);
    clear_both();
    check("R5", 32'(tx_irq), 32'd0);

    // Stop during count, stop together with start.
    write_cfg({half(0, 0, 0, 0), half(1, 0, 0, 20)});
    start(0);
    tick(5);
    stop(0);
    tick(40);
    check("R6", 32'(rx_irq), 32'd0);
    rx_start = 1'b1; rx_stop = 1'b1;
    tick();
    rx_start = 1'b0; rx_stop = 1'b0;
    tick(40);
    check("R6", 32'(rx_irq), 32'd0);

    // Enable low ignores start; clearing enable mid-count.
    write_cfg({half(0, 0, 0, 4), half(0, 0, 0, 0)});
    start(1);
    tick(20);
    check("R7", 32'(tx_irq), 32'd0);
    write_cfg({half(1, 0, 0, 20), half(0, 0, 0, 0)});
    start(1);
    tick(5);
    write_cfg({half(0, 0, 0, 20), half(0, 0, 0, 0)});
    tick(40);
    check("R7", 32'(tx_irq), 32'd0);

    // Rewrite while running keeps the loaded count.
    write_cfg({half(1, 0, 0, 30), half(0, 0, 0, 0)});
    start(1);
    tick(5);
    write_cfg({half(1, 0, 0, 7), half(0, 0, 0, 0)});
    tick(30 - 6);
    check("R8", 32'(tx_irq), 32'd0);
    tick();
    check("R8", 32'(tx_irq), 32'd1);
    clear_both();
    run_expect(1, 7, "R8");

    // Restart while running.
    write_cfg({half(0, 0, 0, 0), half(1, 0, 0, 30)});
    start(0);
    tick(10);
    run_expect(0, 30, "R9");

    // Random patterns on both timers.
    for (int i = 0; i < 60; i++) begin
      bit          tx = 1'($urandom_range(0, 1));
      bit          h  = 1'($urandom_range(0, 1));
      bit          l  = 1'($urandom_range(0, 1));
      int unsigned b  = $urandom_range(0, 20);
      if (tx) write_cfg({half(1, h, l, b), half(0, 1, 1, 8191)});
      else    write_cfg({half(0, 1, 1, 8191), half(1, h, l, b)});
      check("R2", tx ? {16'(cfg_rdata >> 16)} : {16'(cfg_rdata)}, 32'(half(1, h, l, b)));
      run_expect(tx, exp_len(tx, h, l, b), tx ? "R3" : "R4");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule